// File: doc/BRIEF.md
# Multi-Site Pattern Sequencer

This block walks a vector memory under the control of a small instruction program and issues one vector address per test period to the pin formatters. Each instruction names a block of vectors (a start address and a length) and says what to do with it: play it once, repeat it a set number of times, repeat it until told to stop, play it only if the last captured compare result matched, park until a trigger arrives, or halt. Blocks can be visited in any order, because a conditional instruction continues at a target instruction address.

The sequencer runs in one of two partitions. In single-site mode, one engine (site 0) drives every site output in lockstep. In split mode, each of four sites has its own engine, its own instruction port, its own start, stop, trigger and compare inputs, and its own period enable, so sites with different period rates run concurrently. A period is marked by a one-clock `tick_i` pulse per site on the common clock.

Top module: `multi_site_seq`

## Requirements
- R1: During and after reset, every site has `vec_vld_o`, `done_o`, `busy_wait_o` and `active_o` low and `vaddr_o` zero.
- R2: An instruction word is {opcode, start, length, arg} from MSB to LSB, with opcode values RUN=0, LOOP_N=1, LOOP_FOREVER=2, IF_MATCH=3, WAIT_TRIG=4, HALT=5. Each instruction is decoded in one period that issues no vector; RUN then issues start, start+1, ..., start+length-1, one per period, and moves to the next instruction. A length of zero skips the block.
- R3: LOOP_N plays its block arg times in a row, then moves on; an arg of zero skips the block.
- R4: LOOP_FOREVER replays its block until `stop_i` is seen; the stop takes effect at the end of the current pass, after which the site raises `done_o` for one clock and goes idle. A stop pulse outside such a loop has no effect.
- R5: IF_MATCH with a captured match of 1 plays its block once (none if length is zero) and continues at the instruction address in arg; with a captured match of 0 it issues no vector and continues at the next instruction.
- R6: The captured match takes `match_i` only in clocks where `match_vld_i` is high, keeps it otherwise, and is 0 after reset.
- R7: WAIT_TRIG holds `vaddr_o` at the last issued address with `busy_wait_o` high and no vector issued until `trig_i` is high, then continues at the next instruction.
- R8: HALT pulses `done_o` for one clock and returns the site to idle. `start_i` starts a site at instruction 0 only while it is idle; a start while active has no effect.
- R9: `vec_vld_o` is a one-clock pulse, only in the clock after a `tick_i` of the site's engine, with the issued address on `vaddr_o`; a site with no ticks issues nothing.
- R10: In split mode (`split_i`=1) each site fetches from its own instruction port and runs from its own inputs, independently of the others.
- R11: In single-site mode (`split_i`=0) site 0's engine and inputs drive the outputs of all sites identically, and inputs of sites 1 to 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_i | input | 1 | 1: four independent sites, 0: one site over all channels |
| tick_i | input | N_SITES | Per-site period enable |
| start_i | input | N_SITES | Start the site's program at instruction 0 |
| stop_i | input | N_SITES | End the running endless loop after its pass |
| trig_i | input | N_SITES | Trigger that releases a wait |
| match_vld_i | input | N_SITES | Compare result strobe |
| match_i | input | N_SITES | Compare result, 1 = matched |
| iaddr_o | output | N_SITES x PC_W | Instruction address per site |
| idata_i | input | N_SITES x (3+ADDR_W+LEN_W+ARG_W) | Instruction word per site, read combinationally |
| vaddr_o | output | N_SITES x ADDR_W | Issued vector address per site |
| vec_vld_o | output | N_SITES | Vector issued this clock |
| done_o | output | N_SITES | One-clock end-of-program pulse |
| busy_wait_o | output | N_SITES | Site is waiting for a trigger |
| active_o | output | N_SITES | Site is running a program |

## Verification
The bench builds the block with four sites, 8-bit vector addresses, 4-bit lengths, 6-bit counts and 16-entry programs. These small fields let it sweep every block length from 0 to 3 against every loop count from 0 to 3 and compare the full issued address stream with an arithmetic model. Distinct period divisors per site, including a site that never ticks, show the sites advance on their own periods, and the single-site runs show one program mirrored on all outputs while other sites' starts are ignored.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RUN          = 3'd0,
    OP_LOOP_N       = 3'd1,
    OP_LOOP_FOREVER = 3'd2,
    OP_IF_MATCH     = 3'd3,
    OP_WAIT_TRIG    = 3'd4,
    OP_HALT         = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_BLOCK,
    ST_WAIT
  } state_e;
endpackage

// File: rtl/mss_site_engine.sv
module mss_site_engine import mss_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int ARG_W  = 12,
  parameter int PC_W   = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  tick_i,
  input  logic                                  start_i,
  input  logic                                  stop_i,
  input  logic                                  trig_i,
  input  logic                                  match_vld_i,
  input  logic                                  match_i,
  input  logic [OP_W+ADDR_W+LEN_W+ARG_W-1:0]    instr_i,
  output logic [PC_W-1:0]                       pc_o,
  output logic [ADDR_W-1:0]                     vaddr_o,
  output logic                                  vec_vld_o,
  output logic                                  done_o,
  output logic                                  busy_wait_o,
  output logic                                  active_o
);
  localparam int INSTR_W = OP_W + ADDR_W + LEN_W + ARG_W;

  op_e               op;
  logic [ADDR_W-1:0] f_start;
  logic [LEN_W-1:0]  f_len;
  logic [ARG_W-1:0]  f_arg;
  logic [PC_W-1:0]   f_tgt;

  assign op      = op_e'(instr_i[INSTR_W-1 -: OP_W]);
  assign f_start = instr_i[LEN_W+ARG_W +: ADDR_W];
  assign f_len   = instr_i[ARG_W +: LEN_W];
  assign f_arg   = instr_i[ARG_W-1:0];
  assign f_tgt   = f_arg[PC_W-1:0];

  state_e            st_q;
  logic [PC_W-1:0]   pc_q, nxt_pc_q;
  logic [ADDR_W-1:0] base_q, vaddr_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [ARG_W-1:0]  cnt_q;
  logic              fwd_q, stop_q, match_q, vld_q, done_q;

  logic              pass_end, stop_now;
  assign pass_end = (idx_q == len_q - 1'b1);
  assign stop_now = stop_q | stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pc_q     <= '0;
      nxt_pc_q <= '0;
      base_q   <= '0;
      vaddr_q  <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      fwd_q    <= 1'b0;
      stop_q   <= 1'b0;
      match_q  <= 1'b0;
      vld_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      if (match_vld_i) match_q <= match_i;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            pc_q   <= '0;
            stop_q <= 1'b0;
            st_q   <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (tick_i) begin
            // defaults for any block entry
            base_q   <= f_start;
            len_q    <= f_len;
            idx_q    <= '0;
            cnt_q    <= ARG_W'(1);
            fwd_q    <= 1'b0;
            nxt_pc_q <= pc_q + 1'b1;
            case (op)
              OP_RUN: begin
                if (f_len != '0) st_q <= ST_BLOCK;
                else pc_q <= pc_q + 1'b1;
              end
              OP_LOOP_N: begin
                cnt_q <= f_arg;
                if (f_len != '0 && f_arg != '0) st_q <= ST_BLOCK;
                else pc_q <= pc_q + 1'b1;
              end
              OP_LOOP_FOREVER: begin
                fwd_q <= 1'b1;
                if (f_len != '0) st_q <= ST_BLOCK;
                else pc_q <= pc_q + 1'b1;
              end
              OP_IF_MATCH: begin
                nxt_pc_q <= f_tgt;
                if (!match_q) pc_q <= pc_q + 1'b1;
                else if (f_len != '0) st_q <= ST_BLOCK;
                else pc_q <= f_tgt;
              end
              OP_WAIT_TRIG: st_q <= ST_WAIT;
              default: begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end
            endcase
          end
        end
        ST_BLOCK: begin
          if (fwd_q && stop_i) stop_q <= 1'b1;
          if (tick_i) begin
            vaddr_q <= base_q + ADDR_W'(idx_q);
            vld_q   <= 1'b1;
            if (pass_end) begin
              idx_q <= '0;
              if (fwd_q) begin
                if (stop_now) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                end
              end else if (cnt_q == ARG_W'(1)) begin
                pc_q <= nxt_pc_q;
                st_q <= ST_DECODE;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (trig_i) begin
            pc_q <= pc_q + 1'b1;
            st_q <= ST_DECODE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_o        = pc_q;
  assign vaddr_o     = vaddr_q;
  assign vec_vld_o   = vld_q;
  assign done_o      = done_q;
  assign busy_wait_o = (st_q == ST_WAIT);
  assign active_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/mss_site_route.sv
module mss_site_route #(
  parameter int N_SITES = 4,
  parameter int ADDR_W  = 16,
  parameter int PC_W    = 8
) (
  input  logic                             split_i,
  input  logic [N_SITES-1:0]               tick_i,
  input  logic [N_SITES-1:0]               start_i,
  input  logic [N_SITES-1:0]               stop_i,
  input  logic [N_SITES-1:0]               trig_i,
  input  logic [N_SITES-1:0]               mvld_i,
  input  logic [N_SITES-1:0]               match_i,
  output logic [N_SITES-1:0]               e_tick_o,
  output logic [N_SITES-1:0]               e_start_o,
  output logic [N_SITES-1:0]               e_stop_o,
  output logic [N_SITES-1:0]               e_trig_o,
  output logic [N_SITES-1:0]               e_mvld_o,
  output logic [N_SITES-1:0]               e_match_o,
  input  logic [N_SITES-1:0][PC_W-1:0]     e_pc_i,
  input  logic [N_SITES-1:0][ADDR_W-1:0]   e_vaddr_i,
  input  logic [N_SITES-1:0]               e_vld_i,
  input  logic [N_SITES-1:0]               e_done_i,
  input  logic [N_SITES-1:0]               e_wait_i,
  input  logic [N_SITES-1:0]               e_act_i,
  output logic [N_SITES-1:0][PC_W-1:0]     iaddr_o,
  output logic [N_SITES-1:0][ADDR_W-1:0]   vaddr_o,
  output logic [N_SITES-1:0]               vld_o,
  output logic [N_SITES-1:0]               done_o,
  output logic [N_SITES-1:0]               wait_o,
  output logic [N_SITES-1:0]               act_o
);
  for (genvar s = 0; s < N_SITES; s++) begin : g_site
    if (s == 0) begin : g_lead
      assign e_tick_o[s]  = tick_i[s];
      assign e_start_o[s] = start_i[s];
      assign e_stop_o[s]  = stop_i[s];
      assign e_trig_o[s]  = trig_i[s];
      assign e_mvld_o[s]  = mvld_i[s];
      assign e_match_o[s] = match_i[s];
    end else begin : g_follow
      // engines 1..N-1 are parked in single-site mode
      assign e_tick_o[s]  = split_i & tick_i[s];
      assign e_start_o[s] = split_i & start_i[s];
      assign e_stop_o[s]  = split_i & stop_i[s];
      assign e_trig_o[s]  = split_i & trig_i[s];
      assign e_mvld_o[s]  = split_i & mvld_i[s];
      assign e_match_o[s] = match_i[s];
    end
    assign iaddr_o[s] = split_i ? e_pc_i[s]    : e_pc_i[0];
    assign vaddr_o[s] = split_i ? e_vaddr_i[s] : e_vaddr_i[0];
    assign vld_o[s]   = split_i ? e_vld_i[s]   : e_vld_i[0];
    assign done_o[s]  = split_i ? e_done_i[s]  : e_done_i[0];
    assign wait_o[s]  = split_i ? e_wait_i[s]  : e_wait_i[0];
    assign act_o[s]   = split_i ? e_act_i[s]   : e_act_i[0];
  end
endmodule

// File: rtl/multi_site_seq.sv
module multi_site_seq import mss_pkg::*; #(
  parameter int N_SITES = 4,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 12,
  parameter int ARG_W   = 12,
  parameter int PC_W    = 8
) (
  input  logic                                                 clk_i,
  input  logic                                                 rst_ni,
  input  logic                                                 split_i,
  input  logic [N_SITES-1:0]                                   tick_i,
  input  logic [N_SITES-1:0]                                   start_i,
  input  logic [N_SITES-1:0]                                   stop_i,
  input  logic [N_SITES-1:0]                                   trig_i,
  input  logic [N_SITES-1:0]                                   match_vld_i,
  input  logic [N_SITES-1:0]                                   match_i,
  output logic [N_SITES-1:0][PC_W-1:0]                         iaddr_o,
  input  logic [N_SITES-1:0][OP_W+ADDR_W+LEN_W+ARG_W-1:0]      idata_i,
  output logic [N_SITES-1:0][ADDR_W-1:0]                       vaddr_o,
  output logic [N_SITES-1:0]                                   vec_vld_o,
  output logic [N_SITES-1:0]                                   done_o,
  output logic [N_SITES-1:0]                                   busy_wait_o,
  output logic [N_SITES-1:0]                                   active_o
);
  logic [N_SITES-1:0]             e_tick, e_start, e_stop, e_trig, e_mvld, e_match;
  logic [N_SITES-1:0][PC_W-1:0]   e_pc;
  logic [N_SITES-1:0][ADDR_W-1:0] e_vaddr;
  logic [N_SITES-1:0]             e_vld, e_done, e_wait, e_act;

  for (genvar s = 0; s < N_SITES; s++) begin : g_eng
    mss_site_engine #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ARG_W(ARG_W), .PC_W(PC_W)
    ) u_eng (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (e_tick[s]),
      .start_i     (e_start[s]),
      .stop_i      (e_stop[s]),
      .trig_i      (e_trig[s]),
      .match_vld_i (e_mvld[s]),
      .match_i     (e_match[s]),
      .instr_i     (idata_i[s]),
      .pc_o        (e_pc[s]),
      .vaddr_o     (e_vaddr[s]),
      .vec_vld_o   (e_vld[s]),
      .done_o      (e_done[s]),
      .busy_wait_o (e_wait[s]),
      .active_o    (e_act[s])
    );
  end

  mss_site_route #(
    .N_SITES(N_SITES), .ADDR_W(ADDR_W), .PC_W(PC_W)
  ) u_route (
    .split_i   (split_i),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .trig_i    (trig_i),
    .mvld_i    (match_vld_i),
    .match_i   (match_i),
    .e_tick_o  (e_tick),
    .e_start_o (e_start),
    .e_stop_o  (e_stop),
    .e_trig_o  (e_trig),
    .e_mvld_o  (e_mvld),
    .e_match_o (e_match),
    .e_pc_i    (e_pc),
    .e_vaddr_i (e_vaddr),
    .e_vld_i   (e_vld),
    .e_done_i  (e_done),
    .e_wait_i  (e_wait),
    .e_act_i   (e_act),
    .iaddr_o   (iaddr_o),
    .vaddr_o   (vaddr_o),
    .vld_o     (vec_vld_o),
    .done_o    (done_o),
    .wait_o    (busy_wait_o),
    .act_o     (active_o)
  );
endmodule

// File: rtl/multi_site_seq_chk.sv
module multi_site_seq_chk #(
  parameter int N_SITES = 4,
  parameter int ADDR_W  = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           split_i,
  input logic [N_SITES-1:0]             tick_i,
  input logic [N_SITES-1:0][ADDR_W-1:0] vaddr_o,
  input logic [N_SITES-1:0]             vec_vld_o,
  input logic [N_SITES-1:0]             done_o,
  input logic [N_SITES-1:0]             busy_wait_o,
  input logic [N_SITES-1:0]             active_o
);
  for (genvar s = 0; s < N_SITES; s++) begin : g_chk
    AST_VLD_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_vld_o[s] |-> $past(split_i ? tick_i[s] : tick_i[0])); // R9

    AST_VLD_PULSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_vld_o[s] |-> $past(active_o[s])); // R9

    AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_wait_o[s] && $past(busy_wait_o[s])) |-> ($stable(vaddr_o[s]) && !vec_vld_o[s])); // R7

    AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[s] |=> !done_o[s]); // R8

    AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[s] |-> !active_o[s]); // R8

    if (s > 0) begin : g_lock
      AST_SINGLE_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !split_i |-> (vaddr_o[s] == vaddr_o[0] && vec_vld_o[s] == vec_vld_o[0])); // R11
    end
  end
endmodule

bind multi_site_seq multi_site_seq_chk #(
  .N_SITES(N_SITES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .split_i     (split_i),
  .tick_i      (tick_i),
  .vaddr_o     (vaddr_o),
  .vec_vld_o   (vec_vld_o),
  .done_o      (done_o),
  .busy_wait_o (busy_wait_o),
  .active_o    (active_o)
);

// File: tb/multi_site_seq_tb.sv
module multi_site_seq_tb;
  localparam int NS = 4;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int GW = 6;
  localparam int PW = 4;
  localparam int IW = 3 + AW + LW + GW;

  localparam int C_RUN = 0, C_LOOPN = 1, C_EVER = 2, C_IF = 3, C_WAIT = 4, C_HALT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split = 1'b1;
  logic [NS-1:0] tick = '0, start = '0, stop = '0, trig = '0, mvld = '0, mat = '0;
  logic [NS-1:0][PW-1:0] iaddr;
  logic [NS-1:0][IW-1:0] idata;
  logic [NS-1:0][AW-1:0] vaddr;
  logic [NS-1:0] vld, done, bw, act;

  logic [IW-1:0] imem [NS][16];
  int trc [NS][64];
  int tlen [NS];
  int dcnt [NS];
  int div [NS];
  int ex [64];
  int ne;
  int cyc = 0;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  multi_site_seq #(.N_SITES(NS), .ADDR_W(AW), .LEN_W(LW), .ARG_W(GW), .PC_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .split_i(split), .tick_i(tick), .start_i(start),
    .stop_i(stop), .trig_i(trig), .match_vld_i(mvld), .match_i(mat),
    .iaddr_o(iaddr), .idata_i(idata), .vaddr_o(vaddr), .vec_vld_o(vld),
    .done_o(done), .busy_wait_o(bw), .active_o(act));

  for (genvar s = 0; s < NS; s++) begin : g_mem
    assign idata[s] = imem[s][iaddr[s]];
  end

  function automatic logic [IW-1:0] ins(int op, int st, int ln, int ar);
    logic [2:0] o = op[2:0];
    logic [AW-1:0] a = st[AW-1:0];
    logic [LW-1:0] l = ln[LW-1:0];
    logic [GW-1:0] g = ar[GW-1:0];
    return {o, a, l, g};
  endfunction

  // period enables
  initial forever begin
    @(negedge clk);
    cyc++;
    for (int s = 0; s < NS; s++) tick[s] = (div[s] != 0) && ((cyc % div[s]) == 0);
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      if (vld[s] && tlen[s] < 64) begin
        trc[s][tlen[s]] = int'(vaddr[s]);
        tlen[s]++;
      end
      if (done[s]) dcnt[s]++;
    end
  end

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin tlen[s] = 0; dcnt[s] = 0; end
  endtask

  task automatic fill_halt();
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < 16; i++) imem[s][i] = ins(C_HALT, 0, 0, 0);
  endtask

  task automatic kick(input logic [NS-1:0] m);
    @(negedge clk); start = m;
    @(negedge clk); start = '0;
  endtask

  task automatic wait_done(input int s, input string req);
    int t = 0;
    while (dcnt[s] == 0 && t < 3000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    chk(dcnt[s] == 1, req, dcnt[s], 1);
  endtask

  task automatic cmp_trace(input int s, input string req);
    int bad = -1;
    chk(tlen[s] == ne, req, tlen[s], ne);
    for (int i = 0; i < ne && i < tlen[s]; i++)
      if (bad < 0 && trc[s][i] != ex[i]) bad = i;
    if (bad >= 0) chk(1'b0, req, trc[s][bad], ex[bad]);
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic pulse_match(input bit v);
    @(negedge clk); mat[0] = v; mvld[0] = 1'b1;
    @(negedge clk); mat[0] = 1'b0; mvld[0] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin div[s] = 1; tlen[s] = 0; dcnt[s] = 0; end
    fill_halt();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(vld == '0 && done == '0 && bw == '0 && act == '0, "R1 flags in reset", int'({vld, done, bw, act}), 0);
    chk(vaddr == '0, "R1 vaddr in reset", int'(vaddr[0]), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(act == '0 && vld == '0, "R1 idle after reset", int'({act, vld}), 0);

    // R2 / R3 sweep of lengths and counts
    for (int op = C_RUN; op <= C_LOOPN; op++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int c = 0; c < 4; c++) begin
          int reps;
          if (op == C_RUN && c > 0) continue;
          fill_halt();
          imem[0][0] = ins(op, 100, ln, c);
          imem[0][1] = ins(C_RUN, 200, 1, 0);
          reps = (op == C_RUN) ? 1 : c;
          ne = 0;
          if (ln > 0) for (int r = 0; r < reps; r++) for (int k = 0; k < ln; k++) begin ex[ne] = 100 + k; ne++; end
          ex[ne] = 200; ne++;
          clr();
          kick(4'b0001);
          wait_done(0, op == C_RUN ? "R2 run done" : "R3 loop done");
          cmp_trace(0, op == C_RUN ? "R2 run trace" : "R3 loop trace");
        end
      end
    end

    // R10 / R9 concurrent sites, distinct periods; site 3 never ticks
    fill_halt();
    for (int s = 0; s < NS; s++) begin
      imem[s][0] = ins(C_RUN, 16 * s, 3, 0);
      imem[s][1] = ins(C_LOOPN, 16 * s + 8, 2, 2);
      div[s] = s + 1;
    end
    div[3] = 0;
    clr();
    kick(4'b1111);
    for (int s = 0; s < 3; s++) begin
      wait_done(s, "R10 site done");
      ne = 0;
      for (int k = 0; k < 3; k++) begin ex[ne] = 16 * s + k; ne++; end
      for (int r = 0; r < 2; r++) for (int k = 0; k < 2; k++) begin ex[ne] = 16 * s + 8 + k; ne++; end
      cmp_trace(s, "R10 site trace");
    end
    @(negedge clk);
    chk(act[3] == 1'b1 && tlen[3] == 0, "R9 no tick no vector", tlen[3], 0);
    div[3] = 1;
    wait_done(3, "R10 late site done");
    ne = 0;
    for (int k = 0; k < 3; k++) begin ex[ne] = 48 + k; ne++; end
    for (int r = 0; r < 2; r++) for (int k = 0; k < 2; k++) begin ex[ne] = 56 + k; ne++; end
    cmp_trace(3, "R10 late site trace");
    for (int s = 0; s < NS; s++) div[s] = 1;

    // R5 / R6 conditional execution
    fill_halt();
    imem[0][0] = ins(C_IF, 50, 2, 4);
    imem[0][1] = ins(C_RUN, 60, 1, 0);
    imem[0][4] = ins(C_RUN, 70, 1, 0);
    pulse_match(1'b1);
    clr(); kick(4'b0001); wait_done(0, "R5 taken done");
    ne = 3; ex[0] = 50; ex[1] = 51; ex[2] = 70;
    cmp_trace(0, "R5 taken trace");
    pulse_match(1'b0);
    clr(); kick(4'b0001); wait_done(0, "R5 not taken done");
    ne = 1; ex[0] = 60;
    cmp_trace(0, "R5 not taken trace");
    @(negedge clk); mat[0] = 1'b1;
    repeat (3) @(negedge clk); mat[0] = 1'b0;
    clr(); kick(4'b0001); wait_done(0, "R6 no strobe done");
    cmp_trace(0, "R6 match without strobe ignored");
    imem[0][0] = ins(C_IF, 50, 0, 4);
    pulse_match(1'b1);
    clr(); kick(4'b0001); wait_done(0, "R5 empty taken done");
    ne = 1; ex[0] = 70;
    cmp_trace(0, "R5 empty block jumps");

    // R7 trigger wait
    fill_halt();
    imem[0][0] = ins(C_RUN, 30, 2, 0);
    imem[0][1] = ins(C_WAIT, 0, 0, 0);
    imem[0][2] = ins(C_RUN, 33, 1, 0);
    clr(); kick(4'b0001);
    for (int t = 0; t < 200 && !bw[0]; t++) @(negedge clk);
    chk(bw[0] == 1'b1, "R7 busy_wait raised", int'(bw[0]), 1);
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      chk(vaddr[0] == 8'd31 && !vld[0] && bw[0], "R7 hold while waiting", int'(vaddr[0]), 31);
    end
    chk(tlen[0] == 2, "R7 no vectors while waiting", tlen[0], 2);
    @(negedge clk); trig[0] = 1'b1;
    @(negedge clk); trig[0] = 1'b0;
    wait_done(0, "R7 resume done");
    ne = 3; ex[0] = 30; ex[1] = 31; ex[2] = 33;
    cmp_trace(0, "R7 resume trace");

    // R4 / R8 endless loop, stray stop and stray start
    fill_halt();
    imem[0][0] = ins(C_RUN, 120, 4, 0);
    imem[0][1] = ins(C_EVER, 80, 3, 0);
    imem[0][2] = ins(C_RUN, 90, 1, 0);
    clr(); kick(4'b0001);
    while (tlen[0] < 2) @(posedge clk);
    @(negedge clk); stop[0] = 1'b1;
    @(negedge clk); stop[0] = 1'b0;
    while (tlen[0] < 6) @(posedge clk);
    kick(4'b0001);
    while (tlen[0] < 11) @(posedge clk);
    @(negedge clk); stop[0] = 1'b1;
    @(negedge clk); stop[0] = 1'b0;
    wait_done(0, "R4 stop done pulse");
    repeat (10) @(negedge clk);
    chk(act[0] == 1'b0, "R4 idle after stop", int'(act[0]), 0);
    ne = 0;
    for (int k = 0; k < 4; k++) begin ex[ne] = 120 + k; ne++; end
    for (int r = 0; r < 3; r++) for (int k = 0; k < 3; k++) begin ex[ne] = 80 + k; ne++; end
    cmp_trace(0, "R4 R8 trace with stray stop and start");

    // R11 single-site mode
    fill_halt();
    imem[0][0] = ins(C_RUN, 5, 3, 0);
    imem[1][0] = ins(C_RUN, 99, 1, 0);
    @(negedge clk); split = 1'b0;
    clr(); kick(4'b0010);
    repeat (20) @(negedge clk);
    chk(tlen[0] + tlen[1] + tlen[2] + tlen[3] == 0 && act == '0, "R11 other start ignored",
        tlen[0] + tlen[1] + tlen[2] + tlen[3], 0);
    div[0] = 2; div[1] = 0; div[2] = 0; div[3] = 0;
    clr(); kick(4'b0001);
    wait_done(0, "R11 done");
    ne = 3; ex[0] = 5; ex[1] = 6; ex[2] = 7;
    for (int s = 0; s < NS; s++) begin
      cmp_trace(s, "R11 mirrored trace");
      chk(dcnt[s] == 1, "R11 mirrored done", dcnt[s], 1);
    end
    @(negedge clk); split = 1'b1;
    for (int s = 0; s < NS; s++) div[s] = 1;

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule